// File: doc/BRIEF.md
# Memory Bank Retention Control Register

This block is a 32-bit control and status register on a simple register bus. It selects which of eight SRAM banks keep their contents while the chip is in a deep low-power state. Each bank has one enable bit. Bank 0 cannot be turned off, so its bit always reads 1. Banks 1 to 7 can be changed by software, but only while the block reports that the memory is ready.

When an accepted write changes the mask, the block does three things. It clears its ready flag, it stores the new mask, and it sends a one-cycle request carrying that mask to the SRAM power controller. The flag comes back only after the controller acknowledges the request. The flag also drives a level output, which the power-mode sequencer checks before it starts entry into a deep low-power state.

Right after reset the block requests the default all-retained setting on its own. Until that first request is acknowledged, the ready flag is 0.

Top module: `bank_ret_reg`

## Requirements
- R1: While reset is asserted and just after it is released, the register reads 0x000000FF, `sramReady` is 0 and `ctlReq` is 0.
- R2: In the first cycle after reset is released, the block raises `ctlReq` for exactly one cycle with `ctlMask` = 0xFF, without any bus activity.
- R3: The register sits at byte address 0x18. A read there returns the mask in bits 7:0 and the ready flag in bit 16, with all other bits 0. Reads at any other address return 0, and writes to any other address change nothing.
- R4: While ready is 1, a write at 0x18 loads data bits 7:1 into the mask for banks 7 to 1.
- R5: Mask bit 0 always reads 1 and drives `ctlMask[0]` high, whatever value is written to it.
- R6: In the cycle after an accepted write that changes any of mask bits 7:1, `ctlReq` is 1 for exactly that cycle, `ctlMask` carries the new mask and the ready flag reads 0.
- R7: An accepted write that leaves bits 7:1 unchanged raises no request and leaves the ready flag at 1.
- R8: While the ready flag is 0, writes at 0x18 are ignored completely: the mask stays as it was and no request is raised.
- R9: An `ctlAck` pulse while a request is outstanding sets the ready flag in the next cycle. An `ctlAck` with no outstanding request changes nothing.
- R10: `sramReady` always equals read bit 16. Reads have no side effects on the mask, the flag or the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W (12) | Byte address of the access |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, combinational from address |
| ctlReq | output | 1 | One-cycle request to the SRAM power controller |
| ctlMask | output | NUM_BANKS (8) | Current retention mask, bit 0 tied to 1 |
| ctlAck | input | 1 | Acknowledge pulse from the SRAM power controller |
| sramReady | output | 1 | Level ready flag for the power-mode sequencer |

## Verification
The bench writes while the flag is low and then acknowledges. A design without the write lockout would show the second mask at that point, not the first. It sends acknowledges when no request is outstanding, which a design that latched them would turn into a premature ready. It repeats a write with the same mask, where a naive design would drop ready and wait for an acknowledge that never comes. It also writes 0 to bit 0 and accesses a neighbouring address, which catch a writable bank-0 bit and a loose address decode.

// File: rtl/bank_ret_pkg.sv
package bank_ret_pkg;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic loadMask;
    logic clrReady;
    logic setReady;
    logic issueReq;
  } ctlStrobe_t;

  typedef enum logic [1:0] {
    ST_KICK = 2'd0,   // post-reset automatic request
    ST_WAIT = 2'd1,   // request outstanding, waiting for acknowledge
    ST_IDLE = 2'd2    // configuration applied, writes accepted
  } retState_t;

endpackage

// File: rtl/bank_ret_ctrl.sv
module bank_ret_ctrl
  import bank_ret_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wrHit,
  input  logic       wrDiff,
  input  logic       ctlAck,
  output ctlStrobe_t strobe
);

  retState_t stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rst_n) stateQ <= ST_KICK;
    else        stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      ST_KICK: begin
        strobe.issueReq = 1'b1;
        stateD          = ST_WAIT;
      end
      ST_WAIT: begin
        if (ctlAck) begin
          strobe.setReady = 1'b1;
          stateD          = ST_IDLE;
        end
      end
      ST_IDLE: begin
        if (wrHit && wrDiff) begin
          strobe.loadMask = 1'b1;
          strobe.clrReady = 1'b1;
          strobe.issueReq = 1'b1;
          stateD          = ST_WAIT;
        end
      end
      default: stateD = ST_KICK;
    endcase
  end

endmodule

// File: rtl/bank_ret_dp.sv
module bank_ret_dp
  import bank_ret_pkg::*;
#(
  parameter int NUM_BANKS  = 8,
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int REG_OFFSET = 'h18,
  parameter int READY_BIT  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrEn,
  input  logic [DATA_W-1:0]    busWrData,
  input  ctlStrobe_t           strobe,
  output logic [DATA_W-1:0]    busRdData,
  output logic                 wrHit,
  output logic                 wrDiff,
  output logic                 ctlReq,
  output logic [NUM_BANKS-1:0] ctlMask,
  output logic                 readyQ
);

  localparam logic [ADDR_W-1:0] OFFS = ADDR_W'(REG_OFFSET);

  logic                   addrHit;
  logic [NUM_BANKS-1:1]   keepQ;
  logic [NUM_BANKS-1:0]   maskFull;
  logic                   reqQ;
  logic                   unusedWrBits;

  assign addrHit = (busAddr == OFFS);
  assign wrHit   = busWrEn && addrHit;
  assign wrDiff  = (busWrData[NUM_BANKS-1:1] != keepQ);

  // Bits outside the writable mask field are discarded
  assign unusedWrBits = ^{busWrData[DATA_W-1:NUM_BANKS], busWrData[0]};

  // One enable flop per switchable bank; bank 0 is a constant
  for (genvar g = 1; g < NUM_BANKS; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n)               keepQ[g] <= 1'b1;
      else if (strobe.loadMask) keepQ[g] <= busWrData[g];
    end
  end

  assign maskFull = {keepQ, 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      readyQ <= 1'b0;
      reqQ   <= 1'b0;
    end else begin
      reqQ <= strobe.issueReq;
      if (strobe.clrReady)      readyQ <= 1'b0;
      else if (strobe.setReady) readyQ <= 1'b1;
    end
  end

  assign ctlReq  = reqQ;
  assign ctlMask = maskFull;

  always_comb begin
    busRdData = '0;
    if (addrHit) begin
      busRdData[NUM_BANKS-1:0] = maskFull;
      busRdData[READY_BIT]     = readyQ;
    end
  end

endmodule

// File: rtl/bank_ret_reg.sv
module bank_ret_reg
  import bank_ret_pkg::*;
#(
  parameter int NUM_BANKS  = 8,
  parameter int ADDR_W     = 12,
  parameter int REG_OFFSET = 'h18,
  parameter int READY_BIT  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrEn,
  input  logic [31:0]          busWrData,
  output logic [31:0]          busRdData,
  output logic                 ctlReq,
  output logic [NUM_BANKS-1:0] ctlMask,
  input  logic                 ctlAck,
  output logic                 sramReady
);

  ctlStrobe_t strobe;
  logic       wrHit;
  logic       wrDiff;

  bank_ret_ctrl ctrl_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wrHit  (wrHit),
    .wrDiff (wrDiff),
    .ctlAck (ctlAck),
    .strobe (strobe)
  );

  bank_ret_dp #(
    .NUM_BANKS  (NUM_BANKS),
    .ADDR_W     (ADDR_W),
    .DATA_W     (32),
    .REG_OFFSET (REG_OFFSET),
    .READY_BIT  (READY_BIT)
  ) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .strobe    (strobe),
    .busRdData (busRdData),
    .wrHit     (wrHit),
    .wrDiff    (wrDiff),
    .ctlReq    (ctlReq),
    .ctlMask   (ctlMask),
    .readyQ    (sramReady)
  );

endmodule

// File: rtl/bank_ret_chk.sv
module bank_ret_chk #(
  parameter int NUM_BANKS  = 8,
  parameter int ADDR_W     = 12,
  parameter int REG_OFFSET = 'h18,
  parameter int READY_BIT  = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    busAddr,
  input logic                 busWrEn,
  input logic [31:0]          busWrData,
  input logic [31:0]          busRdData,
  input logic                 ctlReq,
  input logic [NUM_BANKS-1:0] ctlMask,
  input logic                 ctlAck,
  input logic                 sramReady
);

  localparam logic [ADDR_W-1:0] OFFS = ADDR_W'(REG_OFFSET);

  logic unusedChk;
  assign unusedChk = ^busWrData;

  // R5
  bank0_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctlMask[0]);

  // R6
  req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctlReq |=> !ctlReq);

  // R6
  req_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctlReq |-> !sramReady);

  // R9
  ready_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sramReady) |-> $past(ctlAck));

  // R8
  lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busWrEn && busAddr == OFFS && !sramReady) |=> $stable(ctlMask));

  // R6
  mask_change_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctlMask) |-> ctlReq);

  // R3
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busRdData[31:READY_BIT+1] == '0) && (busRdData[READY_BIT-1:NUM_BANKS] == '0));

  // R10
  ready_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busAddr == OFFS) |-> (busRdData[READY_BIT] == sramReady));

endmodule

bind bank_ret_reg bank_ret_chk #(
  .NUM_BANKS  (NUM_BANKS),
  .ADDR_W     (ADDR_W),
  .REG_OFFSET (REG_OFFSET),
  .READY_BIT  (READY_BIT)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .busWrData (busWrData),
  .busRdData (busRdData),
  .ctlReq    (ctlReq),
  .ctlMask   (ctlMask),
  .ctlAck    (ctlAck),
  .sramReady (sramReady)
);

// File: tb/bank_ret_reg_tb.sv
module bank_ret_reg_tb_top;

  localparam logic [11:0] REG_ADDR = 12'h018;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] busAddr = REG_ADDR;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        ctlReq;
  logic [7:0]  ctlMask;
  logic        ctlAck = 1'b0;
  logic        sramReady;

  int total = 0;
  int bad = 0;
  logic [7:0] expMask = 8'hFF;

  always #4 clk = ~clk;  // 125 MHz

  bank_ret_reg dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .ctlReq    (ctlReq),
    .ctlMask   (ctlMask),
    .ctlAck    (ctlAck),
    .sramReady (sramReady)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] regImage(input logic [7:0] m, input logic r);
    return {15'd0, r, 8'd0, m};
  endfunction

  // Writes are applied at a falling edge, take effect on the next rising edge,
  // and results are sampled at the following falling edge.
  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    busAddr   = a;
    busWrData = d;
    busWrEn   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWrEn = 1'b0;
    busAddr = REG_ADDR;
  endtask

  task automatic ackPulse();
    ctlAck = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ctlAck = 1'b0;
  endtask

  task automatic readAt(input logic [11:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdData;
    busAddr = REG_ADDR;
    #1;
  endtask

  task automatic test_reset();
    logic [31:0] d;
    readAt(REG_ADDR, d);
    check("R1 read in reset", d, 32'h0000_00FF);
    check("R1 ready in reset", {31'd0, sramReady}, 32'd0);
    check("R1 req in reset", {31'd0, ctlReq}, 32'd0);
  endtask

  task automatic test_init_handshake();
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R2 auto request", {31'd0, ctlReq}, 32'd1);
    check("R2 request mask", {24'd0, ctlMask}, 32'hFF);
    check("R1 ready low before ack", {31'd0, sramReady}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    check("R2 request one cycle", {31'd0, ctlReq}, 32'd0);
    check("R9 still waiting", {31'd0, sramReady}, 32'd0);
    ackPulse();
    check("R9 ready after ack", {31'd0, sramReady}, 32'd1);
  endtask

  task automatic test_write_change();
    logic [31:0] d;
    busWrite(REG_ADDR, 32'hFFFF_FF5A);
    expMask = 8'h5B;
    check("R6 request", {31'd0, ctlReq}, 32'd1);
    check("R6 mask out", {24'd0, ctlMask}, {24'd0, expMask});
    check("R5 bit0 kept", {31'd0, ctlMask[0]}, 32'd1);
    readAt(REG_ADDR, d);
    check("R6 ready cleared", d, regImage(expMask, 1'b0));
    check("R10 sramReady mirror", {31'd0, sramReady}, {31'd0, d[16]});
    @(posedge clk);
    @(negedge clk);
    check("R6 single pulse", {31'd0, ctlReq}, 32'd0);
    ackPulse();
    readAt(REG_ADDR, d);
    check("R4 mask loaded", d, regImage(expMask, 1'b1));
  endtask

  task automatic test_write_same();
    logic [31:0] d;
    busWrite(REG_ADDR, {24'd0, expMask ^ 8'h01});  // only bit 0 differs
    check("R7 no request", {31'd0, ctlReq}, 32'd0);
    readAt(REG_ADDR, d);
    check("R7 ready kept", d, regImage(expMask, 1'b1));
  endtask

  task automatic test_lockout();
    logic [31:0] d;
    busWrite(REG_ADDR, 32'h0000_0000);
    expMask = 8'h01;
    check("R5 bit0 write 0 ignored", {24'd0, ctlMask}, 32'h01);
    @(negedge clk);
    busWrite(REG_ADDR, 32'h0000_00F0);
    check("R8 no request when locked", {31'd0, ctlReq}, 32'd0);
    readAt(REG_ADDR, d);
    check("R8 mask held when locked", d, regImage(expMask, 1'b0));
    ackPulse();
    readAt(REG_ADDR, d);
    check("R8 first mask applied", d, regImage(expMask, 1'b1));
  endtask

  task automatic test_stray_ack();
    logic [31:0] d;
    ackPulse();
    ackPulse();
    check("R9 stray ack no request", {31'd0, ctlReq}, 32'd0);
    readAt(REG_ADDR, d);
    check("R9 stray ack no change", d, regImage(expMask, 1'b1));
    // A stray ack must not pre-arm the next handshake
    busWrite(REG_ADDR, 32'h0000_0080);
    expMask = 8'h81;
    @(posedge clk);
    @(negedge clk);
    check("R9 ready waits for new ack", {31'd0, sramReady}, 32'd0);
    ackPulse();
    check("R9 ready after new ack", {31'd0, sramReady}, 32'd1);
  endtask

  task automatic test_address();
    logic [31:0] d;
    busWrite(12'h01C, 32'h0000_0002);
    check("R3 other addr no request", {31'd0, ctlReq}, 32'd0);
    readAt(12'h01C, d);
    check("R3 other addr reads 0", d, 32'd0);
    readAt(12'h010, d);
    check("R3 other addr reads 0 (2)", d, 32'd0);
    readAt(REG_ADDR, d);
    check("R3 write elsewhere ignored", d, regImage(expMask, 1'b1));
  endtask

  task automatic test_read_no_side();
    logic [31:0] d;
    for (int i = 0; i < 4; i++) begin
      readAt(REG_ADDR, d);
      @(negedge clk);
    end
    check("R10 reads leave flag", {31'd0, sramReady}, 32'd1);
    check("R10 reads no request", {31'd0, ctlReq}, 32'd0);
    check("R10 reads leave mask", {24'd0, ctlMask}, {24'd0, expMask});
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    test_reset();
    test_init_handshake();
    test_write_change();
    test_write_same();
    test_lockout();
    test_stray_ack();
    test_address();
    test_read_no_side();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule